// File: doc/BRIEF.md
# Data Memory Access Unit with Lane Steering

This block sits between a core's load/store pipe and a word-wide synchronous memory. The core hands it word, halfword and byte loads and stores, plus a word swap and a byte swap. The block turns each request into accesses on the word port.

For sub-word loads, the block selects one lane of the word that comes back. The lane depends on the endianness bit sent with the request. A sub-word store is done as read, merge, then write. A swap reads the old contents and writes the new value in one uninterrupted sequence. The core sees no new request accepted until the write-back is done.

A fixed address window faults every access that falls inside it. A faulting access never reaches memory. One debug address takes narrow stores as a character output or a halt request. The block also keeps cycle counters: sequential and non-sequential accesses, and internal and coprocessor cycles that the core reports.

Both core-side channels use valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the unit is idle, so one request is in flight at a time. A response is held, with stable data, until the edge where `rsp_valid` and `rsp_ready` are both high. The memory port has no handshake: a read issued with `mem_en` high and `mem_we` low returns `mem_rdata` on the next edge.

Top module: `mem_lane_unit`

## Requirements
- R1: A byte load returns, zero-extended, the 8 bits starting at bit 8*(E XOR a[1:0]). E is 3 when `req_big` is 1 and 0 when it is 0.
- R2: A halfword load returns, zero-extended, the 16 bits starting at bit 8*(F XOR (a[1:0] AND 2)). F is 2 when `req_big` is 1 and 0 when it is 0. Address bit 0 is ignored.
- R3: A byte or halfword store reads the word, replaces only the lane chosen by R1/R2 with the low bits of the data, and writes the word back. The read is always issued before the write.
- R4: Op code 0 is a word load and returns the whole word. Op code 3 is a word store and writes `req_wdata` with a single write and no read. The other op codes are: 1 halfword load, 2 byte load, 4 halfword store, 5 byte store, 6 word swap, 7 byte swap.
- R5: Any access with an address A where 0x0080_0000 <= A < 0x01A0_0000 is handled as follows:
  - it drives no memory cycle;
  - it responds with `rsp_abort`=1;
  - a load or swap responds with the abort word 0xBAD0_C0DE, or the R1/R2 lane of that word for a sub-word access;
  - it sets `abort_flag`.
- R6: An access outside that window responds with `rsp_abort`=0 and clears `abort_flag`.
- R7: A word swap returns the old word and stores the new one. A byte swap returns the old byte lane and stores the new byte into that lane only.
- R8: A byte or halfword store to address 0x0300_0000 does not touch memory and leaves `abort_flag` unchanged.
  - If the data equals 4, `halt` rises and stays high until reset.
  - Any other value pulses `dbg_char_valid` for one cycle, with `dbg_char` = data[7:0].
- R9: On each accepted request, the access counters are updated:
  - a word load or store adds 1 to `cnt_seq` if `req_seq`=1, and to `cnt_nseq` otherwise;
  - other sub-word loads and stores add 1 to `cnt_nseq`;
  - each swap adds 2 to `cnt_nseq`.
- R10: `int_cyc_valid` adds `int_cyc_amt` to `cnt_int`, and `cop_cyc_valid` adds `cop_cyc_amt` to `cnt_cop`. Either one clears `abort_flag`, and this clear wins over an accept in the same cycle.
- R11: `req_ready` and `rsp_valid` are never high together. A response stalled by `rsp_ready`=0 keeps its data and abort bit unchanged.
- R12: After reset: `req_ready`=1, `rsp_valid`=0, all counters are 0, and `abort_flag`, `halt` and `dbg_char_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this edge when valid |
| req_op | input | 3 | Operation code (R4) |
| req_addr | input | 32 | Byte address |
| req_wdata | input | 32 | Store or swap data |
| req_seq | input | 1 | Word access is sequential |
| req_big | input | 1 | Big-endian lane numbering |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Core takes the response |
| rsp_data | output | 32 | Load or swap result, zero for stores |
| rsp_abort | output | 1 | Access faulted |
| mem_en | output | 1 | Memory cycle enable |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 30 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the read |
| dbg_char_valid | output | 1 | Debug character strobe |
| dbg_char | output | 8 | Debug character |
| halt | output | 1 | Halt requested through debug address |
| int_cyc_valid | input | 1 | Internal cycle report |
| int_cyc_amt | input | 8 | Internal cycles to add |
| cop_cyc_valid | input | 1 | Coprocessor cycle report |
| cop_cyc_amt | input | 8 | Coprocessor cycles to add |
| abort_flag | output | 1 | Last memory access faulted |
| cnt_seq | output | 32 | Sequential access count |
| cnt_nseq | output | 32 | Non-sequential access count |
| cnt_int | output | 32 | Internal cycle count |
| cnt_cop | output | 32 | Coprocessor cycle count |

## Verification
The hardest case to reach is a lane merge under the opposite endianness: the store and the follow-up read must pick the same lane by mirrored rules. The bench sweeps every byte lane and both halfword positions, odd addresses included, under both endianness settings. After each store it reads the whole word back and compares it with a shadow word merged in the bench.

The window edges are hit at the last word below the window, the first and last words inside it, and the first word above it. A monitor on the memory port confirms that faulting requests and debug writes drive no cycle at all. A deliberate stall of the response channel shows that the held data does not move.

// File: rtl/lane_pkg.sv
package lane_pkg;

  typedef enum logic [2:0] {
    OP_LDW = 3'd0,
    OP_LDH = 3'd1,
    OP_LDB = 3'd2,
    OP_STW = 3'd3,
    OP_STH = 3'd4,
    OP_STB = 3'd5,
    OP_SWW = 3'd6,
    OP_SWB = 3'd7
  } lane_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_MRG,
    ST_WR,
    ST_RESP
  } lane_state_e;

  function automatic logic op_is_byte(lane_op_e op);
    return (op == OP_LDB) || (op == OP_STB) || (op == OP_SWB);
  endfunction

  function automatic logic op_is_word(lane_op_e op);
    return (op == OP_LDW) || (op == OP_STW) || (op == OP_SWW);
  endfunction

  function automatic logic op_is_swap(lane_op_e op);
    return (op == OP_SWW) || (op == OP_SWB);
  endfunction

  function automatic logic op_writes(lane_op_e op);
    return (op == OP_STW) || (op == OP_STH) || (op == OP_STB) || op_is_swap(op);
  endfunction

  function automatic logic op_returns(lane_op_e op);
    return (op == OP_LDW) || (op == OP_LDH) || (op == OP_LDB) || op_is_swap(op);
  endfunction

endpackage

// File: rtl/lane_steer.sv
module lane_steer #(
  parameter int DATA_W = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int IDX_W = $clog2(BYTES)
) (
  input  logic [DATA_W-1:0] word_i,
  input  logic [IDX_W-1:0]  addr_lo_i,
  input  logic              byte_i,
  input  logic              big_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] load_o,
  output logic [DATA_W-1:0] merge_o
);
  localparam logic [IDX_W-1:0] FLIP_B = IDX_W'(BYTES - 1);
  localparam logic [IDX_W-1:0] FLIP_H = IDX_W'(BYTES - 2);
  localparam logic [IDX_W-1:0] HALF_ALIGN = ~IDX_W'(1);

  logic [IDX_W-1:0] lane_idx;
  logic [IDX_W+2:0] shamt;
  logic [DATA_W-1:0] mask;

  always_comb begin
    if (byte_i) begin
      lane_idx = (big_i ? FLIP_B : '0) ^ addr_lo_i;
      mask     = DATA_W'(8'hFF);
    end else begin
      lane_idx = (big_i ? FLIP_H : '0) ^ (addr_lo_i & HALF_ALIGN);
      mask     = DATA_W'(16'hFFFF);
    end
    shamt   = {lane_idx, 3'b000};
    load_o  = (word_i >> shamt) & mask;
    merge_o = (word_i & ~(mask << shamt)) | ((wdata_i & mask) << shamt);
  end
endmodule

// File: rtl/lane_addr_decode.sv
module lane_addr_decode
  import lane_pkg::*;
#(
  parameter int          ADDR_W   = 32,
  parameter int unsigned WIN_LO   = 32'h0080_0000,
  parameter int unsigned WIN_HI   = 32'h01A0_0000,
  parameter int unsigned DBG_ADDR = 32'h0300_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  lane_op_e          op_i,
  input  logic              seq_i,
  output logic              in_win_o,
  output logic              dbg_hit_o,
  output logic              seq_inc_o,
  output logic [1:0]        nseq_inc_o
);
  always_comb begin
    in_win_o  = (addr_i >= ADDR_W'(WIN_LO)) && (addr_i < ADDR_W'(WIN_HI));
    dbg_hit_o = ((op_i == OP_STB) || (op_i == OP_STH)) && (addr_i == ADDR_W'(DBG_ADDR));
    seq_inc_o  = 1'b0;
    nseq_inc_o = 2'd1;
    if (op_is_swap(op_i)) begin
      nseq_inc_o = 2'd2;
    end else if (op_is_word(op_i) && seq_i) begin
      seq_inc_o  = 1'b1;
      nseq_inc_o = 2'd0;
    end
  end
endmodule

// File: rtl/lane_cycle_stats.sv
module lane_cycle_stats #(
  parameter int CNT_W = 32,
  parameter int AMT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             acc_fire_i,
  input  logic             seq_inc_i,
  input  logic [1:0]       nseq_inc_i,
  input  logic             flag_touch_i,
  input  logic             flag_set_i,
  input  logic             int_v_i,
  input  logic [AMT_W-1:0] int_amt_i,
  input  logic             cop_v_i,
  input  logic [AMT_W-1:0] cop_amt_i,
  output logic             abort_flag_o,
  output logic [CNT_W-1:0] cnt_seq_o,
  output logic [CNT_W-1:0] cnt_nseq_o,
  output logic [CNT_W-1:0] cnt_int_o,
  output logic [CNT_W-1:0] cnt_cop_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_flag_o <= 1'b0;
      cnt_seq_o    <= '0;
      cnt_nseq_o   <= '0;
      cnt_int_o    <= '0;
      cnt_cop_o    <= '0;
    end else begin
      if (acc_fire_i) begin
        cnt_seq_o  <= cnt_seq_o + CNT_W'(seq_inc_i);
        cnt_nseq_o <= cnt_nseq_o + CNT_W'(nseq_inc_i);
      end
      if (int_v_i) cnt_int_o <= cnt_int_o + CNT_W'(int_amt_i);
      if (cop_v_i) cnt_cop_o <= cnt_cop_o + CNT_W'(cop_amt_i);
      if (int_v_i || cop_v_i) abort_flag_o <= 1'b0;
      else if (flag_touch_i)  abort_flag_o <= flag_set_i;
    end
  end

  assert_report_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_v_i || cop_v_i) |=> !abort_flag_o);
  assert_touch_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_touch_i && flag_set_i && !int_v_i && !cop_v_i) |=> abort_flag_o);
endmodule

// File: rtl/mem_lane_unit.sv
module mem_lane_unit
  import lane_pkg::*;
#(
  parameter int          ADDR_W     = 32,
  parameter int          DATA_W     = 32,
  parameter int          CNT_W      = 32,
  parameter int          AMT_W      = 8,
  parameter int unsigned WIN_LO     = 32'h0080_0000,
  parameter int unsigned WIN_HI     = 32'h01A0_0000,
  parameter int unsigned DBG_ADDR   = 32'h0300_0000,
  parameter logic [31:0] ABORT_WORD = 32'hBAD0_C0DE,
  localparam int IDX_W = $clog2(DATA_W / 8),
  localparam int MA_W  = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_seq,
  input  logic              req_big,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_abort,
  output logic              mem_en,
  output logic              mem_we,
  output logic [MA_W-1:0]   mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dbg_char_valid,
  output logic [7:0]        dbg_char,
  output logic              halt,
  input  logic              int_cyc_valid,
  input  logic [AMT_W-1:0]  int_cyc_amt,
  input  logic              cop_cyc_valid,
  input  logic [AMT_W-1:0]  cop_cyc_amt,
  output logic              abort_flag,
  output logic [CNT_W-1:0]  cnt_seq,
  output logic [CNT_W-1:0]  cnt_nseq,
  output logic [CNT_W-1:0]  cnt_int,
  output logic [CNT_W-1:0]  cnt_cop
);
  lane_state_e       state;
  lane_op_e          op_in, op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, wr_q;
  logic              big_q, abort_q;
  logic              accept, in_win, dbg_hit, seq_inc;
  logic [1:0]        nseq_inc;
  logic [DATA_W-1:0] src_word, lane_load, lane_merge;

  assign op_in     = lane_op_e'(req_op);
  assign req_ready = (state == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rsp_valid = (state == ST_RESP);
  assign mem_en    = (state == ST_RD) || (state == ST_WR);
  assign mem_we    = (state == ST_WR);
  assign mem_addr  = addr_q[ADDR_W-1:IDX_W];
  assign mem_wdata = wr_q;
  assign src_word  = abort_q ? DATA_W'(ABORT_WORD) : mem_rdata;

  lane_addr_decode #(
    .ADDR_W(ADDR_W), .WIN_LO(WIN_LO), .WIN_HI(WIN_HI), .DBG_ADDR(DBG_ADDR)
  ) u_dec (
    .addr_i(req_addr), .op_i(op_in), .seq_i(req_seq),
    .in_win_o(in_win), .dbg_hit_o(dbg_hit),
    .seq_inc_o(seq_inc), .nseq_inc_o(nseq_inc)
  );

  lane_steer #(.DATA_W(DATA_W)) u_steer (
    .word_i(src_word), .addr_lo_i(addr_q[IDX_W-1:0]), .byte_i(op_is_byte(op_q)),
    .big_i(big_q), .wdata_i(wdata_q), .load_o(lane_load), .merge_o(lane_merge)
  );

  lane_cycle_stats #(.CNT_W(CNT_W), .AMT_W(AMT_W)) u_stats (
    .clk(clk), .rst_n(rst_n),
    .acc_fire_i(accept), .seq_inc_i(seq_inc), .nseq_inc_i(nseq_inc),
    .flag_touch_i(accept && !dbg_hit), .flag_set_i(in_win),
    .int_v_i(int_cyc_valid), .int_amt_i(int_cyc_amt),
    .cop_v_i(cop_cyc_valid), .cop_amt_i(cop_cyc_amt),
    .abort_flag_o(abort_flag), .cnt_seq_o(cnt_seq), .cnt_nseq_o(cnt_nseq),
    .cnt_int_o(cnt_int), .cnt_cop_o(cnt_cop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state          <= ST_IDLE;
      op_q           <= OP_LDW;
      addr_q         <= '0;
      wdata_q        <= '0;
      wr_q           <= '0;
      big_q          <= 1'b0;
      abort_q        <= 1'b0;
      rsp_data       <= '0;
      rsp_abort      <= 1'b0;
      dbg_char_valid <= 1'b0;
      dbg_char       <= '0;
      halt           <= 1'b0;
    end else begin
      dbg_char_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          op_q      <= op_in;
          addr_q    <= req_addr;
          wdata_q   <= req_wdata;
          big_q     <= req_big;
          wr_q      <= req_wdata;
          rsp_data  <= '0;
          abort_q   <= 1'b0;
          rsp_abort <= 1'b0;
          if (dbg_hit) begin
            if (req_wdata == DATA_W'(4)) halt <= 1'b1;
            else begin
              dbg_char_valid <= 1'b1;
              dbg_char       <= req_wdata[7:0];
            end
            state <= ST_RESP;
          end else if (in_win) begin
            abort_q   <= 1'b1;
            rsp_abort <= 1'b1;
            state     <= ST_MRG;
          end else if (op_in == OP_STW) begin
            state <= ST_WR;
          end else begin
            state <= ST_RD;
          end
        end
        ST_RD: state <= ST_MRG;
        ST_MRG: begin
          if (op_returns(op_q)) rsp_data <= op_is_word(op_q) ? src_word : lane_load;
          if (!op_is_word(op_q)) wr_q <= lane_merge;
          state <= (!abort_q && op_writes(op_q)) ? ST_WR : ST_RESP;
        end
        ST_WR: state <= ST_RESP;
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_no_mem_in_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_en |-> !abort_q);
  assert_rsp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_abort)));
  assert_one_at_a_time_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_ready && rsp_valid));
  assert_read_before_merge_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !(op_q == OP_STW)) |-> ($past(state) == ST_MRG));
  assert_dbg_no_mem_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_char_valid |-> !mem_en);
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halt);
endmodule

// File: tb/mem_lane_unit_test.sv
module mem_lane_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_seq = 1'b0, req_big = 1'b0;
  logic [2:0]  req_op = '0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        rsp_ready = 1'b0;
  logic        int_cyc_valid = 1'b0, cop_cyc_valid = 1'b0;
  logic [7:0]  int_cyc_amt = '0, cop_cyc_amt = '0;
  logic        req_ready, rsp_valid, rsp_abort, mem_en, mem_we;
  logic [31:0] rsp_data, mem_wdata, cnt_seq, cnt_nseq, cnt_int, cnt_cop;
  logic [31:0] mem_rdata;
  logic [29:0] mem_addr;
  logic        dbg_char_valid, halt, abort_flag;
  logic [7:0]  dbg_char;

  int total = 0, bad = 0;
  int mem_cycles = 0, char_count = 0;
  logic [7:0] last_char;
  logic [31:0] ram [16];
  logic [31:0] shadow [16];
  int exp_seq = 0, exp_nseq = 0;
  logic [31:0] got;
  logic        got_ab;
  bit done = 0;

  localparam logic [31:0] ABW = 32'hBAD0_C0DE;

  always #2 clk = ~clk;

  mem_lane_unit uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata), .req_seq(req_seq),
    .req_big(req_big), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_abort(rsp_abort), .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dbg_char_valid(dbg_char_valid),
    .dbg_char(dbg_char), .halt(halt), .int_cyc_valid(int_cyc_valid),
    .int_cyc_amt(int_cyc_amt), .cop_cyc_valid(cop_cyc_valid), .cop_cyc_amt(cop_cyc_amt),
    .abort_flag(abort_flag), .cnt_seq(cnt_seq), .cnt_nseq(cnt_nseq),
    .cnt_int(cnt_int), .cnt_cop(cnt_cop)
  );

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr[3:0]] <= mem_wdata;
      else mem_rdata <= ram[mem_addr[3:0]];
    end
  end

  always @(negedge clk) begin
    if (mem_en) mem_cycles++;
    if (dbg_char_valid) begin
      char_count++;
      last_char = dbg_char;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int boff(logic [31:0] a, bit big, bit is_byte);
    if (is_byte) return 8 * ((big ? 3 : 0) ^ int'(a[1:0]));
    return 8 * ((big ? 2 : 0) ^ int'(a[1:0] & 2'b10));
  endfunction

  function automatic logic [31:0] pick(logic [31:0] w, logic [31:0] a, bit big, bit is_byte);
    logic [31:0] m = is_byte ? 32'hFF : 32'hFFFF;
    return (w >> boff(a, big, is_byte)) & m;
  endfunction

  function automatic logic [31:0] put(logic [31:0] w, logic [31:0] a, bit big, bit is_byte,
                                      logic [31:0] d);
    logic [31:0] m = is_byte ? 32'hFF : 32'hFFFF;
    int s = boff(a, big, is_byte);
    return (w & ~(m << s)) | ((d & m) << s);
  endfunction

  task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] d,
                       input bit seq, input bit big, input int stall,
                       output logic [31:0] data, output logic ab);
    logic [31:0] held;
    @(negedge clk);
    req_valid = 1; req_op = op; req_addr = a; req_wdata = d; req_seq = seq; req_big = big;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    if (op == 3'd6 || op == 3'd7) exp_nseq += 2;
    else if ((op == 3'd0 || op == 3'd3) && seq) exp_seq += 1;
    else exp_nseq += 1;
    while (!rsp_valid) @(negedge clk);
    held = rsp_data;
    for (int k = 0; k < stall; k++) begin
      @(negedge clk);
      chk("R11 stalled valid", {31'd0, rsp_valid}, 32'd1);
      chk("R11 stalled data", rsp_data, held);
      chk("R11 ready low", {31'd0, req_ready}, 32'd0);
    end
    data = rsp_data; ab = rsp_abort;
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] a;
    int mc;
    for (int i = 0; i < 16; i++) begin
      ram[i] = 32'h1357_9BDF ^ (i * 32'h0102_0408) ^ {i[7:0], 24'h0};
      shadow[i] = ram[i];
    end
    mem_rdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R12 reset state
    chk("R12 req_ready", {31'd0, req_ready}, 32'd1);
    chk("R12 rsp_valid", {31'd0, rsp_valid}, 32'd0);
    chk("R12 counters", cnt_seq | cnt_nseq | cnt_int | cnt_cop, 32'd0);
    chk("R12 flags", {29'd0, abort_flag, halt, dbg_char_valid}, 32'd0);

    for (int big = 0; big < 2; big++) begin
      for (int l = 0; l < 4; l++) begin
        a = 32'd4 + l;
        do_op(3'd2, a, 0, 0, big[0], 0, got, got_ab);
        chk("R1 byte load", got, pick(shadow[1], a, big[0], 1));
        do_op(3'd1, a, 0, 0, big[0], 0, got, got_ab);
        chk("R2 halfword load", got, pick(shadow[1], a, big[0], 0));
      end
      do_op(3'd0, 32'd4, 0, big[0], big[0], 0, got, got_ab);
      chk("R4 word load", got, shadow[1]);
      chk("R6 no abort", {31'd0, got_ab}, 32'd0);
    end

    for (int big = 0; big < 2; big++) begin
      for (int l = 0; l < 4; l++) begin
        a = 32'd8 + l;
        do_op(3'd5, a, 32'hFFFF_FF40 + l + 8 * big, 0, big[0], 0, got, got_ab);
        shadow[2] = put(shadow[2], a, big[0], 1, 32'hFFFF_FF40 + l + 8 * big);
        do_op(3'd0, 32'd8, 0, 0, 0, 0, got, got_ab);
        chk("R3 byte store merge", got, shadow[2]);
        a = 32'd12 + l;
        do_op(3'd4, a, 32'hABCD_0000 + 32'h0111 * (l + 1) + big, 0, big[0], 0, got, got_ab);
        shadow[3] = put(shadow[3], a, big[0], 0, 32'hABCD_0000 + 32'h0111 * (l + 1) + big);
        do_op(3'd0, 32'd12, 0, 0, 0, 0, got, got_ab);
        chk("R3 halfword store merge", got, shadow[3]);
      end
    end

    mc = mem_cycles;
    do_op(3'd3, 32'd16, 32'hCAFE_F00D, 1, 0, 0, got, got_ab);
    chk("R4 word store single write", mem_cycles - mc, 32'd1);
    shadow[4] = 32'hCAFE_F00D;
    do_op(3'd0, 32'd16, 0, 1, 0, 0, got, got_ab);
    chk("R4 word store readback", got, shadow[4]);

    do_op(3'd6, 32'd20, 32'h0DDB_A11A, 0, 0, 0, got, got_ab);
    chk("R7 word swap old", got, shadow[5]);
    shadow[5] = 32'h0DDB_A11A;
    do_op(3'd0, 32'd20, 0, 0, 0, 0, got, got_ab);
    chk("R7 word swap new", got, shadow[5]);
    for (int big = 0; big < 2; big++) begin
      for (int l = 0; l < 4; l++) begin
        a = 32'd24 + l;
        do_op(3'd7, a, 32'h60 + l + 4 * big, 0, big[0], 0, got, got_ab);
        chk("R7 byte swap old", got, pick(shadow[6], a, big[0], 1));
        shadow[6] = put(shadow[6], a, big[0], 1, 32'h60 + l + 4 * big);
      end
    end
    do_op(3'd0, 32'd24, 0, 0, 0, 0, got, got_ab);
    chk("R7 byte swap result", got, shadow[6]);

    mc = mem_cycles;
    do_op(3'd0, 32'h0080_0000, 0, 0, 0, 0, got, got_ab);
    chk("R5 abort word", got, ABW);
    chk("R5 abort bit", {31'd0, got_ab}, 32'd1);
    chk("R5 flag set", {31'd0, abort_flag}, 32'd1);
    do_op(3'd2, 32'h0080_0001, 0, 0, 0, 0, got, got_ab);
    chk("R5 abort byte lane", got, pick(ABW, 32'h0080_0001, 0, 1));
    do_op(3'd3, 32'h019F_FFFC, 32'h1111_2222, 0, 0, 0, got, got_ab);
    chk("R5 store aborted", {31'd0, got_ab}, 32'd1);
    do_op(3'd7, 32'h019F_FFFD, 32'h77, 0, 1, 0, got, got_ab);
    chk("R5 swap abort lane", got, pick(ABW, 32'h019F_FFFD, 1, 1));
    chk("R5 no memory cycles", mem_cycles - mc, 32'd0);
    do_op(3'd0, 32'd60, 0, 0, 0, 0, got, got_ab);
    chk("R5 store discarded", got, shadow[15]);
    chk("R6 flag cleared", {31'd0, abort_flag}, 32'd0);
    do_op(3'd0, 32'h007F_FFFC, 0, 0, 0, 0, got, got_ab);
    chk("R6 below window", {31'd0, got_ab}, 32'd0);
    do_op(3'd0, 32'h01A0_0000, 0, 0, 0, 0, got, got_ab);
    chk("R6 above window", {31'd0, got_ab}, 32'd0);

    do_op(3'd0, 32'h0100_0000, 0, 0, 0, 0, got, got_ab);
    @(negedge clk);
    int_cyc_valid = 1; int_cyc_amt = 8'd5;
    @(negedge clk);
    int_cyc_valid = 0;
    chk("R10 int clears flag", {31'd0, abort_flag}, 32'd0);
    chk("R10 int count", cnt_int, 32'd5);
    cop_cyc_valid = 1; cop_cyc_amt = 8'd9;
    @(negedge clk);
    cop_cyc_amt = 8'd3;
    @(negedge clk);
    cop_cyc_valid = 0;
    chk("R10 cop count", cnt_cop, 32'd12);

    do_op(3'd0, 32'h0100_0000, 0, 0, 0, 0, got, got_ab);
    mc = mem_cycles;
    do_op(3'd5, 32'h0300_0000, 32'h41, 0, 0, 0, got, got_ab);
    chk("R8 char count", char_count, 32'd1);
    chk("R8 char value", {24'd0, last_char}, 32'h41);
    chk("R8 flag unchanged", {31'd0, abort_flag}, 32'd1);
    chk("R8 halt low", {31'd0, halt}, 32'd0);
    do_op(3'd4, 32'h0300_0000, 32'd4, 0, 0, 0, got, got_ab);
    chk("R8 halt set", {31'd0, halt}, 32'd1);
    chk("R8 no char on halt", char_count, 32'd1);
    chk("R8 no memory cycles", mem_cycles - mc, 32'd0);

    do_op(3'd0, 32'd28, 0, 0, 0, 3, got, got_ab);
    chk("R11 stalled result", got, shadow[7]);
    chk("R8 halt sticky", {31'd0, halt}, 32'd1);

    @(negedge clk);
    chk("R9 seq count", cnt_seq, exp_seq);
    chk("R9 nseq count", cnt_nseq, exp_nseq);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule